// File: doc/BRIEF.md
# Crypto Channel Descriptor Fetch FIFO

This block is one channel of the front end of a descriptor-driven crypto engine. Software hands the channel 64-bit descriptor pointers through a small register port. It first writes the lower 32 bits into a staging register. It then writes the upper 32 bits, and that second write places the complete pointer in a fetch queue. The queue holds up to `DEPTH` pointers, 24 by default. When software writes into a full queue, the channel does not stall. It drops the entry and sets a sticky overrun flag.

The channel passes queued pointers one at a time, oldest first, to a request/acknowledge execution port. That port stands in for descriptor fetching and the execution units. When the port acknowledges, the descriptor counts as finished. If writeback is enabled, the channel emits a one-cycle header writeback that stores the byte 0xFF at the descriptor's address. It also sets a sticky done-pending bit. The done interrupt is that bit gated by an enable. A self-clearing channel-reset bit discards the queue and the descriptor in flight, and clears the overrun flag.

Top module: `chan_desc_fifo`

## Requirements
- R1: After the synchronous reset `rst`, the status register and configuration register read 0, and `exec_req`, `wb_valid` and `done_irq` are low.
- R2: A write to the pointer-low register (address 1) only stages the value and enqueues nothing. A write to the pointer-high register (address 2) enqueues `{high word, staged low word}` on that clock edge. The new entry is visible in the occupancy count at the next read.
- R3: Pointers go out in the order they were written. `exec_req` stays high with a stable `exec_ptr` until `exec_ack` is sampled high. `exec_req` is low in the cycle after an acknowledge, so at most one descriptor is outstanding.
- R4: The queue holds at most `DEPTH` waiting entries, excluding the one in flight. A high-register write into a full queue sets the overrun flag, leaves the occupancy at `DEPTH`, and the dropped pointer is never dispatched.
- R5: The overrun flag stays set until a channel reset. Draining the queue or clearing the interrupt does not clear it.
- R6: In the cycle after an acknowledge, `wb_valid` pulses for one cycle with `wb_addr` equal to the finished pointer and `wb_byte` equal to 0xFF, but only when the writeback-enable bit (configuration bit 1) is set. Otherwise no pulse occurs.
- R7: Every completion sets the done-pending bit. `done_irq` equals done-pending AND the interrupt-enable bit (configuration bit 2).
- R8: Writing a 1 in bit 0 of the interrupt-clear register (address 4) clears done-pending. Writing 0 there has no effect.
- R9: Writing configuration (address 0) with bit 0 set empties the queue, drops the descriptor in flight and clears the overrun flag on that edge. Bit 0 then reads back 0, while bits 1 and 2 take the written values. New pointers are accepted afterwards.
- R10: The status register (address 3) reports occupancy in bits 7:0, the overrun flag in bit 16 and done-pending in bit 17.
- R11: When no descriptor is in flight, `exec_ack` is ignored: no writeback pulse occurs and done-pending does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| exec_req | output | 1 | Descriptor offered to the execution port |
| exec_ptr | output | 64 | Pointer of the offered descriptor |
| exec_ack | input | 1 | Execution port reports completion |
| wb_valid | output | 1 | Header writeback strobe |
| wb_addr | output | 64 | Address of the header byte to write |
| wb_byte | output | 8 | Header byte value (0xFF while strobed) |
| done_irq | output | 1 | Masked done interrupt |

## Verification
The assertions check the following on every cycle:
- the request stays held and stable until it is acknowledged;
- occupancy never exceeds the depth;
- the overrun flag is sticky;
- each writeback pulse follows an acknowledge and carries 0xFF;
- the interrupt never rises without its enable;
- a channel reset empties the queue;
- an idle acknowledge produces nothing.

Only the bench scenarios can show some properties. These are the strict oldest-first order across a full 25-descriptor drain with varying acknowledge delays, the exact pointer value of every writeback, the fact that a dropped overrun entry is never dispatched, and the register readback values after a channel reset.

// File: rtl/chfifo_pkg.sv
package chfifo_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int PTR_W  = 64;

    // register word addresses
    localparam logic [ADDR_W-1:0] REG_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_PLO  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_PHI  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] REG_ICLR = 3'd4;

    // configuration bits
    localparam int CFG_RST_BIT = 0;
    localparam int CFG_WB_BIT  = 1;
    localparam int CFG_IRQ_BIT = 2;

    // status bits
    localparam int STAT_OVR_BIT  = 16;
    localparam int STAT_PEND_BIT = 17;

    localparam logic [7:0] DONE_MARK = 8'hFF;

    typedef logic [PTR_W-1:0] desc_ptr_t;

    typedef struct packed {
        logic irq_en;
        logic wb_en;
    } chan_cfg_t;

    typedef struct packed {
        logic      push;
        logic      flush;
        logic      irq_clr;
        desc_ptr_t ptr;
    } reg_cmd_t;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic [7:0] occ,
        input logic       ovr,
        input logic       pend
    );
        logic [DATA_W-1:0] s;
        s = '0;
        s[7:0]          = occ;
        s[STAT_OVR_BIT] = ovr;
        s[STAT_PEND_BIT] = pend;
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg(input chan_cfg_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CFG_WB_BIT]  = c.wb_en;
        v[CFG_IRQ_BIT] = c.irq_en;
        return v;
    endfunction

endpackage

// File: rtl/chfifo_regs.sv
module chfifo_regs
    import chfifo_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  occ,
    input  logic              ovr,
    input  logic              pend,
    output reg_cmd_t          cmd,
    output chan_cfg_t         cfg
);

    logic [DATA_W-1:0] lo_q;
    logic [7:0]        occ_b;

    assign occ_b = 8'(occ);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            lo_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_CFG) begin
                cfg.wb_en  <= wr_data[CFG_WB_BIT];
                cfg.irq_en <= wr_data[CFG_IRQ_BIT];
            end
            if (wr_addr == REG_PLO) begin
                lo_q <= wr_data;
            end
        end
    end

    always_comb begin
        cmd.push    = wr_en && (wr_addr == REG_PHI);
        cmd.flush   = wr_en && (wr_addr == REG_CFG) && wr_data[CFG_RST_BIT];
        cmd.irq_clr = wr_en && (wr_addr == REG_ICLR) && wr_data[0];
        cmd.ptr     = {wr_data, lo_q};
    end

    always_comb begin
        case (rd_addr)
            REG_CFG:  rd_data = pack_cfg(cfg);
            REG_PLO:  rd_data = lo_q;
            REG_STAT: rd_data = pack_status(occ_b, ovr, pend);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/chfifo_queue.sv
module chfifo_queue #(
    parameter int DEPTH = 24,
    parameter int W     = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic             ovr
);

    logic [W-1:0]     mem [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             full;
    logic             accept;
    logic             take;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    assign full   = (count == CNT_W'(DEPTH));
    assign empty  = (count == '0);
    assign accept = push && !full;
    assign take   = pop && !empty;
    assign head   = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (accept && !flush) begin
            mem[wr_idx] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
            ovr    <= 1'b0;
        end else begin
            if (accept) wr_idx <= step(wr_idx);
            if (take)   rd_idx <= step(rd_idx);
            case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) ovr <= 1'b1;
        end
    end

endmodule

// File: rtl/chfifo_dispatch.sv
module chfifo_dispatch
    import chfifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      empty,
    input  desc_ptr_t head,
    output logic      pop,
    output logic      exec_req,
    output desc_ptr_t exec_ptr,
    input  logic      exec_ack,
    input  logic      wb_en,
    input  logic      irq_clr,
    output logic      wb_valid,
    output desc_ptr_t wb_addr,
    output logic      pend
);

    logic      busy;
    desc_ptr_t cur;
    logic      done;

    assign pop      = !busy && !empty && !flush;
    assign done     = busy && exec_ack && !flush;
    assign exec_req = busy;
    assign exec_ptr = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cur      <= '0;
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            pend     <= 1'b0;
        end else begin
            if (flush || done) begin
                busy <= 1'b0;
            end else if (pop) begin
                busy <= 1'b1;
                cur  <= head;
            end
            wb_valid <= done && wb_en;
            if (done) wb_addr <= cur;
            if (done)         pend <= 1'b1;
            else if (irq_clr) pend <= 1'b0;
        end
    end

endmodule

// File: rtl/chan_desc_fifo.sv
module chan_desc_fifo
    import chfifo_pkg::*;
#(
    parameter int DEPTH = 24,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              exec_req,
    output logic [PTR_W-1:0]  exec_ptr,
    input  logic              exec_ack,
    output logic              wb_valid,
    output logic [PTR_W-1:0]  wb_addr,
    output logic [7:0]        wb_byte,
    output logic              done_irq
);

    reg_cmd_t         cmd;
    chan_cfg_t        cfg;
    logic [CNT_W-1:0] occ_cnt;
    logic             ovr_flag;
    logic             pend_q;
    logic             q_empty;
    logic             q_pop;
    desc_ptr_t        q_head;

    chfifo_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .occ(occ_cnt), .ovr(ovr_flag), .pend(pend_q),
        .cmd(cmd), .cfg(cfg)
    );

    chfifo_queue #(.DEPTH(DEPTH), .W(PTR_W)) queue_i (
        .clk(clk), .rst(rst), .flush(cmd.flush),
        .push(cmd.push), .push_data(cmd.ptr), .pop(q_pop),
        .head(q_head), .empty(q_empty), .count(occ_cnt), .ovr(ovr_flag)
    );

    chfifo_dispatch disp_i (
        .clk(clk), .rst(rst), .flush(cmd.flush),
        .empty(q_empty), .head(q_head), .pop(q_pop),
        .exec_req(exec_req), .exec_ptr(exec_ptr), .exec_ack(exec_ack),
        .wb_en(cfg.wb_en), .irq_clr(cmd.irq_clr),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .pend(pend_q)
    );

    assign wb_byte  = wb_valid ? DONE_MARK : 8'h00;
    assign done_irq = pend_q && cfg.irq_en;

endmodule

// File: rtl/chan_desc_fifo_chk.sv
module chan_desc_fifo_chk
    import chfifo_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int CNT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              exec_req,
    input logic [PTR_W-1:0]  exec_ptr,
    input logic              exec_ack,
    input logic              wb_valid,
    input logic [7:0]        wb_byte,
    input logic              done_irq,
    input logic [CNT_W-1:0]  occ,
    input logic              ovr,
    input logic              irq_en
);

    logic rst_wr;
    assign rst_wr = wr_en && (wr_addr == REG_CFG) && wr_data[CFG_RST_BIT];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        exec_req && !exec_ack && !rst_wr |=> exec_req && $stable(exec_ptr)); // R3
    AST_ONE_OUT: assert property (@(posedge clk) disable iff (rst)
        exec_req && exec_ack |=> !exec_req); // R3
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH)); // R4
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovr && !rst_wr |=> ovr); // R5
    AST_WB_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(exec_req && exec_ack)); // R6
    AST_WB_MARK: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> wb_byte == 8'hFF); // R6
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> irq_en); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        rst_wr |=> occ == '0 && !exec_req && !ovr); // R9
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !exec_req && exec_ack |=> !wb_valid); // R11

endmodule

bind chan_desc_fifo chan_desc_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .exec_req(exec_req), .exec_ptr(exec_ptr), .exec_ack(exec_ack),
    .wb_valid(wb_valid), .wb_byte(wb_byte), .done_irq(done_irq),
    .occ(occ_cnt), .ovr(ovr_flag), .irq_en(cfg.irq_en)
);

// File: tb/chan_desc_fifo_tb_top.sv
module chan_desc_fifo_tb_top;

    localparam int DEPTH = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        exec_req;
    logic [63:0] exec_ptr;
    logic        exec_ack = 1'b0;
    logic        wb_valid;
    logic [63:0] wb_addr;
    logic [7:0]  wb_byte;
    logic        done_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    chan_desc_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .exec_req(exec_req), .exec_ptr(exec_ptr), .exec_ack(exec_ack),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_byte(wb_byte),
        .done_irq(done_irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic [63:0] mkptr(input int k);
        return {32'h1000_0000 + 32'(k), 32'(k) * 32'h40};
    endfunction

    task automatic push(input logic [63:0] p);
        wr(3'd1, p[31:0]);
        wr(3'd2, p[63:32]);
    endtask

    task automatic finish_one(input logic [63:0] exp, input int dly, input bit exp_wb, input string tag);
        for (int i = 0; i < 8 && !exec_req; i++) @(negedge clk);
        check(exec_req == 1'b1, {tag, " R3 request"}, 64'(exec_req), 64'd1);
        check(exec_ptr == exp, {tag, " R3 order"}, exec_ptr, exp);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check(exec_req && exec_ptr == exp, {tag, " R3 hold"}, exec_ptr, exp);
        end
        exec_ack = 1'b1;
        @(negedge clk);
        exec_ack = 1'b0;
        check(wb_valid == exp_wb, {tag, " R6 strobe"}, 64'(wb_valid), 64'(exp_wb));
        if (exp_wb) begin
            check(wb_addr == exp, {tag, " R6 address"}, wb_addr, exp);
            check(wb_byte == 8'hFF, {tag, " R6 byte"}, 64'(wb_byte), 64'hFF);
        end
        check(exec_req == 1'b0, {tag, " R3 single outstanding"}, 64'(exec_req), 64'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd3, v); check(v == 32'd0, "R1 status", 64'(v), 0);
        rd(3'd0, v); check(v == 32'd0, "R1 config", 64'(v), 0);
        check(!exec_req && !wb_valid && !done_irq, "R1 outputs", 64'({exec_req, wb_valid, done_irq}), 0);

        wr(3'd0, 32'h6);
        rd(3'd0, v); check(v == 32'h6, "R10 config readback", 64'(v), 64'h6);

        // R2 low half alone enqueues nothing
        wr(3'd1, 32'hDEAD_0000);
        repeat (2) @(negedge clk);
        rd(3'd3, v); check(v[7:0] == 8'd0, "R2 low write no push", 64'(v[7:0]), 0);
        check(exec_req == 1'b0, "R2 low write no request", 64'(exec_req), 0);

        // fill: one in flight plus DEPTH queued
        for (int k = 1; k <= DEPTH + 1; k++) begin
            push(mkptr(k));
            rd(3'd3, v);
            if (k == 1) begin
                check(v[7:0] == 8'd1, "R2 push visible", 64'(v[7:0]), 1);
                check(exec_req == 1'b0, "R2 not yet dispatched", 64'(exec_req), 0);
            end else begin
                check(v[7:0] == 8'(k - 1), "R4 occupancy", 64'(v[7:0]), 64'(k - 1));
            end
        end
        rd(3'd3, v);
        check(v[16] == 1'b0, "R4 no overrun at capacity", 64'(v[16]), 0);
        push(mkptr(99));
        rd(3'd3, v);
        check(v[16] == 1'b1, "R4 overrun set", 64'(v[16]), 1);
        check(v[7:0] == 8'(DEPTH), "R4 occupancy held", 64'(v[7:0]), 64'(DEPTH));

        // drain in order with varied ack delays
        for (int k = 1; k <= DEPTH + 1; k++) begin
            finish_one(mkptr(k), k % 4, 1'b1, "drain");
            rd(3'd3, v);
            check(v[7:0] == 8'(DEPTH + 1 - k), "R4 drain occupancy", 64'(v[7:0]), 64'(DEPTH + 1 - k));
        end
        repeat (4) @(negedge clk);
        check(exec_req == 1'b0, "R4 dropped entry never sent", 64'(exec_req), 0);
        rd(3'd3, v);
        check(v[16] == 1'b1, "R5 overrun sticky", 64'(v[16]), 1);
        check(v[17] == 1'b1 && done_irq, "R7 pending and irq", 64'({v[17], done_irq}), 64'h3);

        // R8 clear
        wr(3'd4, 32'h0);
        rd(3'd3, v); check(v[17] == 1'b1, "R8 zero write ignored", 64'(v[17]), 1);
        wr(3'd4, 32'h1);
        rd(3'd3, v); check(v[17] == 1'b0 && !done_irq, "R8 cleared", 64'({v[17], done_irq}), 0);
        check(v[16] == 1'b1, "R5 overrun survives clear", 64'(v[16]), 1);

        // R7 gating
        wr(3'd0, 32'h2);
        push(mkptr(100));
        finish_one(mkptr(100), 1, 1'b1, "gate");
        rd(3'd3, v);
        check(v[17] == 1'b1 && !done_irq, "R7 masked", 64'({v[17], done_irq}), 64'h2);
        wr(3'd0, 32'h6);
        check(done_irq == 1'b1, "R7 unmasked", 64'(done_irq), 1);
        wr(3'd4, 32'h1);

        // R6 writeback disabled
        wr(3'd0, 32'h4);
        push(mkptr(101));
        finish_one(mkptr(101), 0, 1'b0, "nowb");
        rd(3'd3, v); check(v[17] == 1'b1, "R7 pending without writeback", 64'(v[17]), 1);
        wr(3'd4, 32'h1);

        // R9 channel reset
        wr(3'd0, 32'h6);
        for (int k = 200; k < 203; k++) push(mkptr(k));
        rd(3'd3, v);
        check(v[7:0] == 8'd2 && exec_req && exec_ptr == mkptr(200), "R9 pre-reset state", exec_ptr, mkptr(200));
        wr(3'd0, 32'h7);
        rd(3'd3, v);
        check(v[7:0] == 8'd0, "R9 flushed", 64'(v[7:0]), 0);
        check(v[16] == 1'b0, "R9 overrun cleared", 64'(v[16]), 0);
        check(exec_req == 1'b0, "R9 in-flight dropped", 64'(exec_req), 0);
        rd(3'd0, v); check(v == 32'h6, "R9 reset bit self-clears", 64'(v), 64'h6);
        repeat (4) @(negedge clk);
        check(exec_req == 1'b0, "R9 stays idle", 64'(exec_req), 0);

        // R11 idle ack
        @(negedge clk); exec_ack = 1'b1;
        @(negedge clk); exec_ack = 1'b0;
        check(wb_valid == 1'b0, "R11 no writeback", 64'(wb_valid), 0);
        rd(3'd3, v); check(v[17] == 1'b0, "R11 pending unchanged", 64'(v[17]), 0);

        push(mkptr(300));
        finish_one(mkptr(300), 2, 1'b1, "R9 after reset");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule